// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block removes read-after-write hazards at the execute stage of a five-stage in-order pipeline. For each of the two ALU operands it compares the source register number of the instruction in execute with the destination numbers held in the execute/memory and memory/writeback pipeline registers. It then produces a 2-bit select and the operand value that the select picks.

Each operand has three candidate values: the value read from the register file in decode, the ALU result still in the execute/memory register, and the value about to be written back. The newer in-flight result is preferred over the older one. A stage that does not write a register never supplies a value. A destination of register 0 never supplies a value either, because that register always reads as zero.

The block has no clock and no state. Every output follows its inputs within the same cycle. Stall insertion for load-use cases, branch handling and the register file itself belong to neighbouring logic.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage qualifies for an operand, its select is 2'b00 and the operand equals the register-file value for that operand.
- R2: When the execute/memory stage has its write flag set, a nonzero destination, and a destination equal to the operand's source, the select is 2'b10 and the operand equals `exm_result_i`.
- R3: When only the memory/writeback stage qualifies (write flag set, nonzero destination, destination equals source), the select is 2'b01 and the operand equals `mwb_result_i`.
- R4: When both stages qualify for the same operand, the execute/memory stage wins: the select is 2'b10.
- R5: A stage whose write flag is clear never supplies an operand, even when its destination equals the source.
- R6: A destination of 0 never supplies an operand, even with the write flag set and a source of 0.
- R7: Operand A is decided only from `exe_rs_i`, and operand B only from `exe_rt_i`. The two decisions are independent of each other.
- R8: The select code 2'b11 is never produced. The operand multiplexer treats any code it does not list as a request for the register-file value.
- R9: Selects and operands are purely combinational and settle in the same cycle as the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| exe_rs_i | input | 5 | First source register number of the instruction in execute |
| exe_rt_i | input | 5 | Second source register number of the instruction in execute |
| exe_rf_a_i | input | 32 | Register-file value read for the first source |
| exe_rf_b_i | input | 32 | Register-file value read for the second source |
| exm_we_i | input | 1 | Register-write flag of the execute/memory register |
| exm_rd_i | input | 5 | Destination register number in the execute/memory register |
| exm_result_i | input | 32 | ALU result held in the execute/memory register |
| mwb_we_i | input | 1 | Register-write flag of the memory/writeback register |
| mwb_rd_i | input | 5 | Destination register number in the memory/writeback register |
| mwb_result_i | input | 32 | Value being written back |
| sel_a_o | output | 2 | Select for operand A (00 register file, 10 execute/memory, 01 writeback) |
| sel_b_o | output | 2 | Select for operand B (same encoding) |
| opnd_a_o | output | 32 | Operand A presented to the ALU |
| opnd_b_o | output | 32 | Operand B presented to the ALU |

## Verification
Directed runs replay a producer instruction followed by four consumers that read its result from A only, from B only, from both, and as a store base. These runs show that each operand's select follows the producer as it moves from one stage to the next.

Further corner cases separate the write-flag gate from the zero-register gate, and test both stages matching at once so that the priority between them becomes visible. Random runs draw register numbers from a narrow range, which makes matches, double matches and register 0 frequent. They also vary the write flags, so that mistakes in the comparisons, the gates and the priority show up as wrong selects or wrong operand values.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WBACK   = 2'b01,
        SRC_EXMEM   = 2'b10
    } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_W = 5
) (
    input  logic             we_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic [REG_W-1:0] src_i,
    output logic             hit_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit_o = we_i && (dst_i != ZERO_REG) && (dst_i == src_i);
    end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             src_i,
    input  logic             exm_we_i,
    input  logic [REG_W-1:0] exm_rd_i,
    input  logic             mwb_we_i,
    input  logic [REG_W-1:0] mwb_rd_i,
    input  logic [REG_W-1:0] reg_i,
    output fwd_src_e         sel_o
);
    logic exm_hit;
    logic mwb_hit;

    fwd_match #(.REG_W(REG_W)) u_exm_match (
        .we_i  (exm_we_i),
        .dst_i (exm_rd_i),
        .src_i (reg_i),
        .hit_o (exm_hit)
    );

    fwd_match #(.REG_W(REG_W)) u_mwb_match (
        .we_i  (mwb_we_i),
        .dst_i (mwb_rd_i),
        .src_i (reg_i),
        .hit_o (mwb_hit)
    );

    always_comb begin
        unique case ({exm_hit, mwb_hit})
            2'b10, 2'b11: sel_o = SRC_EXMEM;
            2'b01:        sel_o = SRC_WBACK;
            default:      sel_o = SRC_REGFILE;
        endcase
    end

    logic unused_src;
    assign unused_src = src_i;
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel_i,
    input  logic [DATA_W-1:0] rf_i,
    input  logic [DATA_W-1:0] exm_i,
    input  logic [DATA_W-1:0] mwb_i,
    output logic [DATA_W-1:0] opnd_o
);
    always_comb begin
        case (sel_i)
            SRC_EXMEM: opnd_o = exm_i;
            SRC_WBACK: opnd_o = mwb_i;
            default:   opnd_o = rf_i;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int DW = DATA_W
) (
    input  logic [RW-1:0] exe_rs_i,
    input  logic [RW-1:0] exe_rt_i,
    input  logic [DW-1:0] exe_rf_a_i,
    input  logic [DW-1:0] exe_rf_b_i,
    input  logic          exm_we_i,
    input  logic [RW-1:0] exm_rd_i,
    input  logic [DW-1:0] exm_result_i,
    input  logic          mwb_we_i,
    input  logic [RW-1:0] mwb_rd_i,
    input  logic [DW-1:0] mwb_result_i,
    output logic [1:0]    sel_a_o,
    output logic [1:0]    sel_b_o,
    output logic [DW-1:0] opnd_a_o,
    output logic [DW-1:0] opnd_b_o
);
    localparam int NUM_OPS = 2;

    logic [RW-1:0] src_reg [NUM_OPS];
    logic [DW-1:0] rf_val  [NUM_OPS];
    logic [1:0]    sel     [NUM_OPS];
    logic [DW-1:0] opnd    [NUM_OPS];

    always_comb begin
        src_reg[0] = exe_rs_i;
        src_reg[1] = exe_rt_i;
        rf_val[0]  = exe_rf_a_i;
        rf_val[1]  = exe_rf_b_i;
    end

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        fwd_src_e sel_e;

        fwd_select #(.REG_W(RW)) u_sel (
            .src_i    (1'b0),
            .exm_we_i (exm_we_i),
            .exm_rd_i (exm_rd_i),
            .mwb_we_i (mwb_we_i),
            .mwb_rd_i (mwb_rd_i),
            .reg_i    (src_reg[op]),
            .sel_o    (sel_e)
        );

        assign sel[op] = sel_e;

        fwd_mux #(.DATA_W(DW)) u_mux (
            .sel_i  (sel[op]),
            .rf_i   (rf_val[op]),
            .exm_i  (exm_result_i),
            .mwb_i  (mwb_result_i),
            .opnd_o (opnd[op])
        );

        always_comb begin
            // R2
            exm_bypass_chk: assert (!(exm_we_i && exm_rd_i != '0 && exm_rd_i == src_reg[op])
                                    || opnd[op] == exm_result_i);
            // R5
            no_writer_chk: assert (exm_we_i || mwb_we_i || sel[op] == SRC_REGFILE);
            // R6
            zero_dst_chk: assert (exm_rd_i != '0 || mwb_rd_i != '0 || opnd[op] == rf_val[op]);
            // R8
            no_code3_chk: assert (sel[op] != 2'b11);
        end
    end

    assign sel_a_o  = sel[0];
    assign sel_b_o  = sel[1];
    assign opnd_a_o = opnd[0];
    assign opnd_b_o = opnd[1];
endmodule

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [4:0]  rs, rt, exm_rd, mwb_rd;
    logic [31:0] rfa, rfb, exm_res, mwb_res;
    logic        exm_we, mwb_we;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] op_a, op_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    fwd_unit uut (
        .exe_rs_i(rs), .exe_rt_i(rt), .exe_rf_a_i(rfa), .exe_rf_b_i(rfb),
        .exm_we_i(exm_we), .exm_rd_i(exm_rd), .exm_result_i(exm_res),
        .mwb_we_i(mwb_we), .mwb_rd_i(mwb_rd), .mwb_result_i(mwb_res),
        .sel_a_o(sel_a), .sel_b_o(sel_b), .opnd_a_o(op_a), .opnd_b_o(op_b)
    );

    function automatic logic [1:0] exp_sel(input logic [4:0] src);
        bit e, m;
        e = exm_we && exm_rd != 0 && exm_rd == src;
        m = mwb_we && mwb_rd != 0 && mwb_rd == src;
        if (e) return 2'b10;
        if (m) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_op(input logic [1:0] s, input logic [31:0] rf);
        if (s == 2'b10) return exm_res;
        if (s == 2'b01) return mwb_res;
        return rf;
    endfunction

    function automatic string req_of(input logic [4:0] src);
        bit e, m;
        e = exm_we && exm_rd != 0 && exm_rd == src;
        m = mwb_we && mwb_rd != 0 && mwb_rd == src;
        if (e && m) return "R4";
        if (e) return "R2";
        if (m) return "R3";
        if ((exm_rd == src && exm_rd != 0) || (mwb_rd == src && mwb_rd != 0)) return "R5";
        if (src == 0 && (exm_we || mwb_we)) return "R6";
        return "R1";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [1:0] ea, eb;
        #(CLK_PERIOD/4);
        ea = exp_sel(rs);
        eb = exp_sel(rt);
        check({tag, " R7 sel_a ", req_of(rs)}, {30'd0, sel_a}, {30'd0, ea});
        check({tag, " R7 sel_b ", req_of(rt)}, {30'd0, sel_b}, {30'd0, eb});
        check({tag, " R9 opnd_a ", req_of(rs)}, op_a, exp_op(ea, rfa));
        check({tag, " R9 opnd_b ", req_of(rt)}, op_b, exp_op(eb, rfb));
        // R8
        check({tag, " R8 no code 3"}, {31'd0, sel_a == 2'b11 || sel_b == 2'b11}, 32'd0);
    endtask

    task automatic set_stages(input logic ew, input logic [4:0] ed,
                              input logic mw, input logic [4:0] md);
        @(negedge clk);
        exm_we = ew; exm_rd = ed; mwb_we = mw; mwb_rd = md;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rs = 0; rt = 0; exm_rd = 0; mwb_rd = 0; exm_we = 0; mwb_we = 0;
        rfa = 32'hA0A0_0001; rfb = 32'hB0B0_0002;
        exm_res = 32'h1111_1111; mwb_res = 32'h2222_2222;
        @(negedge clk);
        check_all("idle R1");

        // producer writes reg 1; consumers follow
        set_stages(1, 5'd1, 0, 5'd0); rs = 1; rt = 5;
        check_all("sub R2");
        set_stages(1, 5'd4, 1, 5'd1); rs = 7; rt = 1;
        check_all("and R3");
        set_stages(1, 5'd6, 0, 5'd4); rs = 1; rt = 1;
        check_all("or R1");
        set_stages(1, 5'd8, 1, 5'd6); rs = 1; rt = 4;
        check_all("sw R1");
        // R4 both stages match
        set_stages(1, 5'd3, 1, 5'd3); rs = 3; rt = 3;
        check_all("both R4");
        // R5 write flag clear
        set_stages(0, 5'd3, 0, 5'd3);
        check_all("nowe R5");
        set_stages(0, 5'd3, 1, 5'd3);
        check_all("exm off R5");
        // R6 destination zero
        set_stages(1, 5'd0, 1, 5'd0); rs = 0; rt = 0;
        check_all("zero R6");
        set_stages(1, 5'd0, 1, 5'd2); rs = 0; rt = 2;
        check_all("zero mix R6");

        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rs = 5'($urandom_range(0, 3));
            rt = 5'($urandom_range(0, 3));
            exm_rd = 5'($urandom_range(0, 3));
            mwb_rd = 5'($urandom_range(0, 3));
            exm_we = 1'($urandom);
            mwb_we = 1'($urandom);
            rfa = $urandom; rfb = $urandom; exm_res = $urandom; mwb_res = $urandom;
            if (i % 50 == 0) begin
                rs = 5'($urandom); rt = 5'($urandom);
            end
            check_all("rand");
        end
        finish_run();
    end
endmodule